// File: doc/BRIEF.md
# Legacy Interrupt Request Handshake Sequencer

This block collects device events into sticky status bits and turns them into a single level interrupt request for a bus interface core. The core converts that level into interrupt assert and deassert messages on the bus. The core reports back, on an acknowledge input, the interrupt state it is currently presenting on the bus. There are three event sources: DMA completion on bit 0, CAN activity on bit 1 and an error condition on bit 2. Each source has a status bit that software clears by writing a one to it. Each source also has an enable bit that gates whether the bit can request an interrupt.

The request is driven by a four-state machine:
- **IDLE**: request low. Moves to ASSERTING when an enabled status bit is set and the acknowledge is low.
- **ASSERTING**: request high. Moves to ASSERTED once the acknowledge goes high.
- **ASSERTED**: request high. Moves to DEASSERTING when no enabled status bit remains set.
- **DEASSERTING**: request low. Moves to IDLE once the acknowledge goes low.

Because of this hold-off, the request is never raised again until the core shows that the deassert has reached the bus. An event that arrives during the hold-off stays pending and raises the request as soon as the hold-off ends. Clearing the enables while a status bit is still set drops the request. Enabling them again produces a fresh interrupt.

Top module: `irq_handshake_seq`

## Requirements
- R1: An event pulse on a source sets that source's status bit after the next clock edge, and the bit then stays set until it is cleared. The bit order is DMA = bit 0, CAN = bit 1, error = bit 2.
- R2: A cycle with `clr_we` high clears every status bit whose `clr_data` bit is 1, after the clock edge. Status bits whose `clr_data` bit is 0 are unchanged.
- R3: When an event pulse and a clear of the same bit fall in the same cycle, the bit is left set.
- R4: From IDLE with the acknowledge low, an event on an enabled source raises `int_req` two clock edges after the event is sampled.
- R5: Once raised, `int_req` stays high until `int_ack` has been seen high, even if the status is cleared first.
- R6: When no enabled status bit remains set, `int_req` drops. This holds whether the bits were cleared or the enables were cleared.
- R7: After `int_req` drops, it stays low for as long as `int_ack` is still high.
- R8: An event that arrives during the hold-off stays pending. It raises `int_req` in the second cycle after `int_ack` is seen low.
- R9: Setting an enable while its status bit is still set produces a fresh request. Once the handshake settles, `int_req` equals the OR of the enabled status bits.
- R10: After reset, `status` is zero, `int_req` is low and the machine is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | NUM_SRC | One-cycle event pulses (bit 0 DMA, bit 1 CAN, bit 2 error) |
| irq_enable | input | NUM_SRC | Per-source interrupt enables from the control register |
| clr_we | input | 1 | Write strobe for the write-one-to-clear status access |
| clr_data | input | NUM_SRC | Bits to clear when `clr_we` is high |
| int_ack | input | 1 | Interrupt state the bus core currently presents on the bus |
| int_req | output | 1 | Level interrupt request to the bus core |
| status | output | NUM_SRC | Sticky event status bits |

## Verification
The bench builds the block with the default NUM_SRC of 3, so every source has its own status and enable bit. It drives the block against a core model whose acknowledge trails the request by three cycles. That lag is long enough for events and clears to land inside each state of the handshake, including the DEASSERTING hold-off. With three sources, the bench can also have one bit keep the request alive while another bit is cleared, disabled or re-enabled.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_ASSERTING   = 2'd1,
        ST_ASSERTED    = 2'd2,
        ST_DEASSERTING = 2'd3
    } req_state_e;

    localparam int SRC_DMA = 0;
    localparam int SRC_CAN = 1;
    localparam int SRC_ERR = 2;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_data,
    output logic [NUM_SRC-1:0] status
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                status[i] <= 1'b0;
            else if (evt_pulse[i])
                status[i] <= 1'b1;          // event wins over a same-cycle clear
            else if (clr_we && clr_data[i])
                status[i] <= 1'b0;
        end
    end

    // R1 / R3: every pulsed bit is set on the next cycle
    assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((status & $past(evt_pulse)) == $past(evt_pulse)));

    // R2: without a clear write no set bit goes away
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/irq_pending_gate.sv
module irq_pending_gate #(
    parameter int NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] irq_enable,
    output logic               pend
);
    always_comb pend = |(status & irq_enable);
endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic int_ack,
    output logic int_req
);
    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (pend && !int_ack) state_d = ST_ASSERTING;
            ST_ASSERTING:   if (int_ack)          state_d = ST_ASSERTED;
            ST_ASSERTED:    if (!pend)            state_d = ST_DEASSERTING;
            ST_DEASSERTING: if (!int_ack)         state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_ASSERTING, ST_ASSERTED: int_req = 1'b1;
            default:                   int_req = 1'b0;
        endcase
    end

    // R7: a rising request is only allowed after the acknowledge was low
    assert_rise_after_ack_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_req) |-> !$past(int_ack));

    // R5: an unacknowledged assert is held
    assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASSERTING && !int_ack) |=> int_req);

    // R6: losing all enabled causes drops the request next cycle
    assert_drop_when_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASSERTED && !pend) |=> !int_req);

    // R8: pending work at the end of the hold-off leads to a new request
    assert_pending_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pend && !int_ack) |=> int_req);
endmodule

// File: rtl/irq_handshake_seq.sv
module irq_handshake_seq #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic [NUM_SRC-1:0] irq_enable,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_data,
    input  logic               int_ack,
    output logic               int_req,
    output logic [NUM_SRC-1:0] status
);
    logic pend;

    irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .clr_we    (clr_we),
        .clr_data  (clr_data),
        .status    (status)
    );

    irq_pending_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .status     (status),
        .irq_enable (irq_enable),
        .pend       (pend)
    );

    irq_req_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .int_ack (int_ack),
        .int_req (int_req)
    );

    // R10: clean state right after reset
    assert_reset_clean_R10: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && !int_req));
endmodule

// File: tb/irq_handshake_seq_tb.sv
module irq_handshake_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 3;
    localparam int SETTLE     = 20;
    localparam int ACK_LAG    = 3;
    localparam int NVEC       = 12;

    // {evt, enable, clear, expected status, expected int_req}
    localparam logic [12:0] VEC [NVEC] = '{
        {3'b001, 3'b111, 3'b000, 3'b001, 1'b1},  // R1 R4 DMA event
        {3'b010, 3'b111, 3'b000, 3'b011, 1'b1},  // R1 CAN event
        {3'b000, 3'b111, 3'b001, 3'b010, 1'b1},  // R2 clear DMA only
        {3'b000, 3'b111, 3'b010, 3'b000, 1'b0},  // R6 all cleared
        {3'b100, 3'b011, 3'b000, 3'b100, 1'b0},  // R9 error disabled
        {3'b000, 3'b111, 3'b000, 3'b100, 1'b1},  // R9 re-enable
        {3'b000, 3'b000, 3'b000, 3'b100, 1'b0},  // R6 enables dropped
        {3'b000, 3'b100, 3'b000, 3'b100, 1'b1},  // R9 fresh request
        {3'b100, 3'b100, 3'b100, 3'b100, 1'b1},  // R3 event beats clear
        {3'b000, 3'b100, 3'b111, 3'b000, 1'b0},  // R2 clear all
        {3'b011, 3'b111, 3'b000, 3'b011, 1'b1},  // R1 two events
        {3'b000, 3'b111, 3'b011, 3'b000, 1'b0}   // R6 cleared
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_pulse = '0;
    logic [N-1:0] irq_enable = '0;
    logic         clr_we = 1'b0;
    logic [N-1:0] clr_data = '0;
    logic         int_ack;
    logic         int_req;
    logic [N-1:0] status;
    logic [ACK_LAG-1:0] ack_pipe;

    int checks = 0;
    int fails  = 0;
    int holdoff_viol = 0;
    bit waiting = 1'b0;
    bit prev_req = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // simple bus core model: acknowledge follows request after a lag
    always_ff @(posedge clk) begin
        if (!rst_n) ack_pipe <= '0;
        else        ack_pipe <= {ack_pipe[ACK_LAG-2:0], int_req};
    end
    assign int_ack = ack_pipe[ACK_LAG-1];

    irq_handshake_seq #(.NUM_SRC(N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_pulse  (evt_pulse),
        .irq_enable (irq_enable),
        .clr_we     (clr_we),
        .clr_data   (clr_data),
        .int_ack    (int_ack),
        .int_req    (int_req),
        .status     (status)
    );

    // R7 monitor: after a drop, no rise while acknowledge is still high
    always @(negedge clk) begin
        if (rst_n) begin
            if (waiting && int_req) holdoff_viol++;
            if (prev_req && !int_req) waiting = 1'b1;
            if (!int_ack) waiting = 1'b0;
            prev_req = int_req;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R10 reset state
        tick(3);
        chk("R10 status in reset", 32'(status), 32'h0);
        chk("R10 int_req in reset", 32'(int_req), 32'h0);
        rst_n = 1'b1;
        tick(2);
        chk("R10 status after reset", 32'(status), 32'h0);
        chk("R10 int_req after reset", 32'(int_req), 32'h0);

        // vector table walk
        for (int v = 0; v < NVEC; v++) begin
            evt_pulse  = VEC[v][12:10];
            irq_enable = VEC[v][9:7];
            clr_data   = VEC[v][6:4];
            clr_we     = (VEC[v][6:4] != '0);
            tick(1);
            evt_pulse = '0;
            clr_we    = 1'b0;
            clr_data  = '0;
            tick(SETTLE);
            chk($sformatf("table step %0d status", v), 32'(status), 32'(VEC[v][3:1]));
            chk($sformatf("table step %0d int_req", v), 32'(int_req), 32'(VEC[v][0]));
        end

        // R4 exact latency from idle
        irq_enable = 3'b111;
        evt_pulse  = 3'b001;
        tick(1);
        evt_pulse = '0;
        chk("R4 int_req one edge after event", 32'(int_req), 32'h0);
        chk("R1 status one edge after event", 32'(status), 32'h1);
        tick(1);
        chk("R4 int_req two edges after event", 32'(int_req), 32'h1);

        // R7 / R8 hold-off: clear, then new event during DEASSERTING
        tick(SETTLE);
        clr_we = 1'b1; clr_data = 3'b001;
        tick(1);
        clr_we = 1'b0; clr_data = '0;
        tick(1);
        chk("R6 int_req dropped after clear", 32'(int_req), 32'h0);
        evt_pulse = 3'b010;
        tick(1);
        evt_pulse = '0;
        tick(1);
        chk("R7 ack still high during hold-off", 32'(int_ack), 32'h1);
        chk("R7 int_req low during hold-off", 32'(int_req), 32'h0);
        tick(2);
        chk("R7 int_req low until ack low seen", 32'(int_req), 32'h0);
        tick(1);
        chk("R8 pending event raises after hold-off", 32'(int_req), 32'h1);
        chk("R8 pending status kept", 32'(status), 32'h2);

        // R5 assert held until acknowledged although status cleared
        tick(SETTLE);
        clr_we = 1'b1; clr_data = 3'b111;
        tick(1);
        clr_we = 1'b0; clr_data = '0;
        tick(SETTLE);
        evt_pulse = 3'b001;
        tick(1);
        evt_pulse = '0;
        clr_we = 1'b1; clr_data = 3'b001;
        tick(1);
        clr_we = 1'b0; clr_data = '0;
        chk("R5 request raised", 32'(int_req), 32'h1);
        tick(2);
        chk("R5 ack not yet seen", 32'(int_ack), 32'h0);
        chk("R5 request held without ack", 32'(int_req), 32'h1);
        tick(SETTLE);
        chk("R6 request gone once settled", 32'(int_req), 32'h0);

        chk("R7 monitor hold-off violations", 32'(holdoff_viol), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule